// File: doc/BRIEF.md
# MDIO Command Register Master

This block lets a host manage an external Ethernet PHY through one 32-bit command/status word. A single write packs the whole request: a go flag, a direction flag, the PHY address, the register address and, for writes, the 16-bit value. The block then clocks a clause-22 management frame out on MDC/MDIO, and it controls the MDIO output enable so that the PHY can answer on reads.

The go flag doubles as the busy indicator. It reads back as 1 for the whole transaction and drops to 0 when the last MDC period ends. For a read, the value the PHY returned replaces the low half of the same word. The host polls the busy flag, then reads the result.

MDC runs only during a transaction. It is the system clock divided by a parameterized half-period count. MDIO outputs change on MDC falling edges, and input data is sampled on MDC rising edges.

Top module: `mdio_cmd_master`

## Requirements
- R1: A write with bit 31 set while idle starts a transaction. Bit 31 reads 1 from the cycle after that write until the transaction completes, then reads 0.
- R2: Bit 30 of the written word selects the direction: 1 sends opcode bits 1,0 (read) and 0 sends opcode bits 0,1 (write).
- R3: The frame is, MSB first: PRE_LEN ones, start bits 0,1, two opcode bits, the PHY address from bits 25:21, the register address from bits 20:16, two turnaround bits, then 16 data bits. On a write the turnaround is 1,0 and the data are bits 15:0 of the written word.
- R4: MDIO is driven (output enable 1) for every bit of a write frame and for the first PRE_LEN+14 bits of a read frame. It is released from the first turnaround bit through the last data bit of a read, and it is released whenever the block is idle.
- R5: A read samples MDIO on each MDC rising edge of the 16 data bits. After completion the word reads {busy=0, bit 30=1, bits 29:26=0, PHY address, register address, captured data}. After a write it reads the written fields with bits 15:0 equal to the written data.
- R6: MDC is low while idle. Each MDC half period lasts MDC_HALF system clocks, and a transaction lasts 2*MDC_HALF*(PRE_LEN+32) clocks from the accepting edge to busy clearing.
- R7: The MDIO output value changes only in the cycle in which MDC falls.
- R8: A write arriving while busy is ignored. The frame in flight, the stored fields and the result are unchanged, and no second frame follows.
- R9: A write with bit 31 clear while idle starts nothing and leaves the read-back word unchanged, and MDC stays low.
- R10: After reset the read-back word is 0, MDC is 0, the output enable is 0 and the MDIO output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe for the command word |
| regWrData | input | 32 | Command word written by the host |
| regRdData | output | 32 | Command/status word read back by the host |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable (1 = block drives) |
| mdioIn | input | 1 | MDIO value seen on the pad |

## Verification
The bench builds the block with MDC_HALF = 2 and the standard 32-bit preamble. The short divider keeps each 64-bit frame to 256 clocks, so reads and writes with all-zero, all-one and mixed address and data values fit in a short run. The preamble stays at full length, so the expected frames are exactly the clause-22 layout. With a half period of two clocks the divider's wrap point lands between cycles, so an off-by-one in the half-period count shows up as a wrong transaction length. The same setting makes a late or early MDIO edge visible against the MDC falling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // command word field positions (host-visible)
  localparam int CMD_GO  = 31;
  localparam int CMD_RD  = 30;
  localparam int PHY_LSB = 21;
  localparam int REG_LSB = 16;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  // frame layout after the preamble
  localparam int HDR_BITS  = 14;  // start + opcode + phy + reg
  localparam int TA_BITS   = 2;
  localparam int POST_BITS = HDR_BITS + TA_BITS + DATA_W;

  typedef struct packed {
    logic load;      // accept a new command
    logic shiftOut;  // advance outgoing shift register (MDC fall)
    logic sampleIn;  // capture MDIO (MDC rise, data bits)
    logic done;      // last MDC fall of the frame
    logic inPre;     // current bit belongs to the preamble
    logic outRel;    // release MDIO (read turnaround/data)
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrGo,
  input  logic      rdSel,
  input  logic      busyIn,
  output logic      mdc,
  output mdioStrb_t strb
);
  localparam int FRAME_BITS = PRE_LEN + POST_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_START = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] TA_START  = CNT_W'(PRE_LEN + HDR_BITS);
  localparam logic [CNT_W-1:0] DAT_START = CNT_W'(PRE_LEN + HDR_BITS + TA_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(MDC_HALF - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             mdcQ;
  logic             halfTick;
  logic             riseTick;
  logic             fallTick;

  assign halfTick = (state == ST_RUN) && (divCnt == DIV_LAST);
  assign riseTick = halfTick && !mdcQ;
  assign fallTick = halfTick && mdcQ;
  assign mdc      = mdcQ;

  always_comb begin
    strb          = '0;
    strb.load     = wrEn && wrGo && (state == ST_IDLE);
    strb.shiftOut = fallTick && (bitCnt >= HDR_START) && (bitCnt != LAST_BIT);
    strb.sampleIn = riseTick && (bitCnt >= DAT_START);
    strb.done     = fallTick && (bitCnt == LAST_BIT);
    strb.inPre    = bitCnt < HDR_START;
    strb.outRel   = (state == ST_RUN) && rdSel && (bitCnt >= TA_START);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      mdcQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state  <= ST_RUN;
            divCnt <= '0;
            bitCnt <= '0;
            mdcQ   <= 1'b0;
          end
        end
        default: begin
          if (halfTick) begin
            divCnt <= '0;
            mdcQ   <= ~mdcQ;
            if (fallTick) begin
              if (bitCnt == LAST_BIT) begin
                state  <= ST_IDLE;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_BUSY_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    busyIn == (state == ST_RUN)); // R1
  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !mdcQ); // R6
  AST_NO_RESTART_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> !strb.load); // R8
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  mdioStrb_t   strb,
  input  logic        mdc,
  input  logic        mdioIn,
  output logic        busy,
  output logic        rdSel,
  output logic [31:0] rdData,
  output logic        mdioOut,
  output logic        mdioOe
);
  logic              busyQ;
  logic              rdQ;
  logic [ADDR_W-1:0] phyQ;
  logic [ADDR_W-1:0] regQ;
  logic [DATA_W-1:0] dataQ;
  logic [POST_BITS-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [1:0]        opCode;

  assign opCode = wrData[CMD_RD] ? 2'b10 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      rdQ     <= 1'b0;
      phyQ    <= '0;
      regQ    <= '0;
      dataQ   <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.load) begin
        busyQ   <= 1'b1;
        rdQ     <= wrData[CMD_RD];
        phyQ    <= wrData[PHY_LSB +: ADDR_W];
        regQ    <= wrData[REG_LSB +: ADDR_W];
        dataQ   <= wrData[DATA_W-1:0];
        txShift <= {2'b01, opCode, wrData[PHY_LSB +: ADDR_W],
                    wrData[REG_LSB +: ADDR_W], 2'b10, wrData[DATA_W-1:0]};
      end else begin
        if (strb.shiftOut)
          txShift <= {txShift[POST_BITS-2:0], 1'b0};
        if (strb.sampleIn && rdQ)
          rxShift <= {rxShift[DATA_W-2:0], mdioIn};
        if (strb.done) begin
          busyQ <= 1'b0;
          if (rdQ)
            dataQ <= rxShift;
        end
      end
    end
  end

  assign busy    = busyQ;
  assign rdSel   = rdQ;
  assign rdData  = {busyQ, rdQ, 4'b0000, phyQ, regQ, dataQ};
  assign mdioOut = (busyQ && !strb.inPre) ? txShift[POST_BITS-1] : 1'b1;
  assign mdioOe  = busyQ && !strb.outRel;

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> $fell(mdc)); // R7
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && wrEn) |=> ($stable(phyQ) && $stable(regQ) && $stable(rdQ))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && !(wrEn && wrData[CMD_GO])) |=> $stable(rdData)); // R9
  AST_NO_DRIVE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && rdQ && strb.sampleIn) |-> !mdioOe); // R4
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrb_t strb;
  logic      busy;
  logic      rdSel;

  mdio_ctrl #(
    .MDC_HALF (MDC_HALF),
    .PRE_LEN  (PRE_LEN)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .wrGo   (regWrData[CMD_GO]),
    .rdSel  (rdSel),
    .busyIn (busy),
    .mdc    (mdc),
    .strb   (strb)
  );

  mdio_dpath uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .wrData  (regWrData),
    .strb    (strb),
    .mdc     (mdc),
    .mdioIn  (mdioIn),
    .busy    (busy),
    .rdSel   (rdSel),
    .rdData  (regRdData),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );
endmodule

// File: tb/sim_mdio_cmd_master.sv
module sim_mdio_cmd_master;
  localparam int HALF  = 2;
  localparam int PRE   = 32;
  localparam int FBITS = PRE + 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int tests = 0;
  int fails = 0;
  int r7Bad = 0;
  int unexpected = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] bits;
    logic        rd;
    logic [15:0] rdVal;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  mdio_cmd_master #(.MDC_HALF(HALF), .PRE_LEN(PRE)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdWord(input bit go, input bit rd,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {go, rd, 4'b0000, phy, rg, d};
  endfunction

  // driver: push the expected frame, then write the command
  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input logic [15:0] phyVal,
                       output int cycles);
    item_t it;
    it.bits  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    it.rd    = rd;
    it.rdVal = phyVal;
    q.push_back(it);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = cmdWord(1'b1, rd, phy, rg, d);
    @(negedge clk);
    regWrEn = 1'b0;
    chk(regRdData[31] == 1'b1, "R1 busy set after start", {63'b0, regRdData[31]}, 64'd1);
    cycles = 0;
    while (regRdData[31] && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  // monitor: PHY model plus frame scoreboard
  initial begin : monitor
    logic [63:0] capBits, capOe, mask, oeExp;
    int cnt;
    logic prevMdc, prevOut;
    item_t it;
    cnt = 0; capBits = '0; capOe = '0;
    @(posedge rstN);
    @(negedge clk);
    prevMdc = mdc; prevOut = mdioOut;
    forever begin
      @(negedge clk);
      if (mdioOut !== prevOut && !(prevMdc && !mdc)) r7Bad++;
      if (mdc && !prevMdc) begin
        if (cnt == 0 && q.size() == 0) unexpected++;
        capBits[63-cnt] = mdioOut;
        capOe[63-cnt]   = mdioOe;
        cnt++;
        if (cnt == FBITS) begin
          cnt = 0;
          if (q.size() > 0) begin
            it = q.pop_front();
            mask  = it.rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
            oeExp = it.rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
            chk((capBits & mask) == (it.bits & mask), "R2/R3 frame bits",
                capBits & mask, it.bits & mask);
            chk(capOe == oeExp, "R4 output enable pattern", capOe, oeExp);
          end
        end
      end
      if (!mdc && prevMdc) begin
        if (cnt >= 48 && q.size() > 0 && q[0].rd) mdioIn = q[0].rdVal[63-cnt];
        else mdioIn = 1'b1;
      end
      prevMdc = mdc;
      prevOut = mdioOut;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int cyc;
    logic [31:0] snap;
    bit mdcSeen;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(regRdData == 32'h0, "R10 reset word", {32'b0, regRdData}, 64'h0);
    chk(mdc == 1'b0 && mdioOe == 1'b0 && mdioOut == 1'b1, "R10 reset pins",
        {61'b0, mdc, mdioOe, mdioOut}, 64'h1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // write, mixed fields; R6 length
    issue(1'b0, 5'd5, 5'h1A, 16'hBEEF, 16'h0, cyc);
    chk(cyc == 2*HALF*FBITS, "R6 transaction length", cyc, 2*HALF*FBITS);
    chk(regRdData == cmdWord(1'b0, 1'b0, 5'd5, 5'h1A, 16'hBEEF), "R5 word after write",
        regRdData, cmdWord(1'b0, 1'b0, 5'd5, 5'h1A, 16'hBEEF));
    chk(mdc == 1'b0 && mdioOe == 1'b0, "R6 idle pins after write", {mdc, mdioOe}, 0);

    // reads with corner patterns
    issue(1'b1, 5'd31, 5'd0, 16'h0, 16'hA5C3, cyc);
    chk(regRdData == cmdWord(1'b0, 1'b1, 5'd31, 5'd0, 16'hA5C3), "R5 read A5C3",
        regRdData, cmdWord(1'b0, 1'b1, 5'd31, 5'd0, 16'hA5C3));
    chk(cyc == 2*HALF*FBITS, "R6 read length", cyc, 2*HALF*FBITS);
    issue(1'b1, 5'd0, 5'd31, 16'hFFFF, 16'h0000, cyc);
    chk(regRdData == cmdWord(1'b0, 1'b1, 5'd0, 5'd31, 16'h0000), "R5 read 0000",
        regRdData, cmdWord(1'b0, 1'b1, 5'd0, 5'd31, 16'h0000));
    issue(1'b1, 5'd21, 5'd10, 16'h0, 16'hFFFF, cyc);
    chk(regRdData == cmdWord(1'b0, 1'b1, 5'd21, 5'd10, 16'hFFFF), "R5 read FFFF",
        regRdData, cmdWord(1'b0, 1'b1, 5'd21, 5'd10, 16'hFFFF));
    issue(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0, cyc);
    chk(regRdData == cmdWord(1'b0, 1'b0, 5'd0, 5'd0, 16'h0000), "R2 write zero word",
        regRdData, 64'h0);

    // R8: write while busy is ignored
    fork
      issue(1'b1, 5'd3, 5'd4, 16'h0, 16'h1234, cyc);
      begin
        repeat (60) @(negedge clk);
        regWrEn   = 1'b1;
        regWrData = cmdWord(1'b1, 1'b0, 5'd9, 5'd9, 16'hFFFF);
        @(negedge clk);
        regWrEn = 1'b0;
      end
    join
    chk(regRdData == cmdWord(1'b0, 1'b1, 5'd3, 5'd4, 16'h1234), "R8 busy write ignored",
        regRdData, cmdWord(1'b0, 1'b1, 5'd3, 5'd4, 16'h1234));
    chk(cyc == 2*HALF*FBITS, "R8 frame length undisturbed", cyc, 2*HALF*FBITS);
    mdcSeen = 0;
    repeat (20) begin @(negedge clk); if (mdc) mdcSeen = 1; end
    chk(!mdcSeen && !regRdData[31], "R8 no second frame", {mdcSeen, regRdData[31]}, 0);

    // R9: write with go clear while idle
    snap = regRdData;
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = cmdWord(1'b0, 1'b1, 5'd17, 5'd17, 16'h7777);
    @(negedge clk);
    regWrEn = 1'b0;
    chk(regRdData == snap, "R9 word unchanged", regRdData, snap);
    mdcSeen = 0;
    repeat (20) begin @(negedge clk); if (mdc) mdcSeen = 1; end
    chk(!mdcSeen, "R9 MDC stays low", mdcSeen, 0);

    chk(r7Bad == 0, "R7 MDIO changes only on MDC fall", r7Bad, 0);
    chk(unexpected == 0 && q.size() == 0, "R8 scoreboard drained", unexpected + q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule